// File: doc/BRIEF.md
# DMA Address and Byte-Count Sequencer

This block keeps the address and count state for two DMA channels. Each channel holds a 26-bit requester address, a 26-bit target address and a 24-bit byte counter. When a channel's step strobe is high, the unit advances both addresses and takes the transfer size off the counter. A transfer moves either one byte or one word. Each address has its own direction input, so it can count up or count down.

A small overflow-enable register holds two bits per channel. The first bit controls the target address and the byte counter together. The second bit controls the requester address. When a bit is clear, arithmetic on the parts it governs stays inside the low 16 bits and the upper bits keep their value. When a bit is set, carries and borrows run through the full width.

The counter is loaded with the byte total minus one, so that the step which borrows past zero is the last step. The unit signals that step with a one-cycle terminal-count pulse. Software loads and reads the registers through a simple select-based write port and read port.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, every address, counter and overflow-enable bit reads as zero, and both terminal-count outputs are low.
- R2: The select code is {channel, field}. The channel is bit 2. The field is bits 1:0, with 00 = requester address, 01 = target address, 10 = byte counter and 11 = overflow-enable register. The field code 11 selects the same register for either channel. A write stores wrData in the selected register. rdData returns the selected register, zero-extended. The counter keeps only wrData[23:0].
- R3: The overflow-enable register has these bits: bit 0 = channel 0 target/count, bit 1 = channel 0 requester, bit 2 = channel 1 target/count, bit 3 = channel 1 requester. Writes to every bit above bit 3 are ignored, and those bits read as zero.
- R4: A byte step (stepWord=0) moves each address by 1, upward when its direction input is 0 and downward when it is 1. The same step lowers the counter by 1.
- R5: A word step (stepWord=1) moves each address by 2 and lowers the counter by 2. A counter loaded with 2N-1 therefore expires on the N-th word step.
- R6: When a governing enable bit is 0, only bits 15:0 of the affected address or counter change, with wraparound inside those bits. All higher bits keep their value.
- R7: When a governing enable bit is 1, the full register width (26 bits for an address, 24 bits for the counter) increments or decrements with carry or borrow.
- R8: The requester enable acts only on the requester address. The target/count enable acts on both the target address and the byte counter.
- R9: termCnt[c] is high for exactly the one cycle after a step on channel c whose counter update borrows past zero. The borrow is out of bits 15:0 in 16-bit mode and out of all 24 bits in full mode. Otherwise termCnt[c] is low.
- R10: A register write in the same cycle as a step on that channel takes priority for the written register. The other registers of the channel still step. Terminal count does not fire when the counter write overrides the step.
- R11: A step or a register write on one channel leaves the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write select {channel, field} |
| wrData | input | 26 | Write data |
| rdSel | input | 3 | Read select {channel, field} |
| rdData | output | 26 | Read data for rdSel, zero-extended |
| stepCh | input | 2 | Per-channel transfer step strobe |
| stepWord | input | 2 | Per-channel transfer size, 1 = word |
| reqDec | input | 2 | Per-channel requester direction, 1 = decrement |
| tgtDec | input | 2 | Per-channel target direction, 1 = decrement |
| termCnt | output | 2 | Per-channel terminal-count pulse |

## Verification
A wrong enable routing, or carry logic that ignores the mode, shows up on the first step that crosses a 64K boundary. The upper address bits then move when they should be frozen, or stay put when they should carry. The fault is visible on rdData in the cycle after that step. A wrong borrow point appears on termCnt one cycle after the faulty step. It shows either as a missing pulse when the low 16 bits wrap, or as a false pulse at a 64K boundary in full mode. A priority error between a write and a step leaves a stepped value, not the written one, at the next read.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    F_REQ = 2'd0,
    F_TGT = 2'd1,
    F_CNT = 2'd2,
    F_OVF = 2'd3
  } field_t;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadTgt;
    logic loadCnt;
    logic step;
    logic word;
    logic reqDec;
    logic tgtDec;
    logic reqFull;
    logic tgtFull;
  } chStrobe_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int OVF_W = 2 * NCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W+1:0]   wrSel,
  input  logic [OVF_W-1:0]  wrOvf,
  input  logic [NCH-1:0]    stepCh,
  input  logic [NCH-1:0]    stepWord,
  input  logic [NCH-1:0]    reqDec,
  input  logic [NCH-1:0]    tgtDec,
  output chStrobe_t         strobe [NCH],
  output logic [OVF_W-1:0]  ovfQ
);

  logic [CH_W-1:0] wrCh;
  field_t          wrField;

  assign wrCh    = wrSel[CH_W+1:2];
  assign wrField = field_t'(wrSel[1:0]);

  // Overflow-enable register: only the implemented bits exist
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ <= '0;
    end else if (wrEn && wrField == F_OVF) begin
      ovfQ <= wrOvf;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    logic chHit;
    assign chHit = wrEn && (wrCh == CH_W'(c));
    always_comb begin
      strobe[c].loadReq = chHit && (wrField == F_REQ);
      strobe[c].loadTgt = chHit && (wrField == F_TGT);
      strobe[c].loadCnt = chHit && (wrField == F_CNT);
      strobe[c].step    = stepCh[c];
      strobe[c].word    = stepWord[c];
      strobe[c].reqDec  = reqDec[c];
      strobe[c].tgtDec  = tgtDec[c];
      strobe[c].tgtFull = ovfQ[2*c];
      strobe[c].reqFull = ovfQ[2*c+1];
    end
  end

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 24,
  parameter int LOW_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe [NCH],
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] reqQ [NCH],
  output logic [ADDR_W-1:0] tgtQ [NCH],
  output logic [CNT_W-1:0]  cntQ [NCH],
  output logic [NCH-1:0]    termCnt
);

  // Address update: full-width or confined to the low field
  function automatic logic [ADDR_W-1:0] addrNext(
    input logic [ADDR_W-1:0] a,
    input logic              dec,
    input logic              word,
    input logic              full
  );
    logic [ADDR_W-1:0] d;
    logic [ADDR_W-1:0] s;
    d = word ? ADDR_W'(2) : ADDR_W'(1);
    s = dec ? (a - d) : (a + d);
    return full ? s : {a[ADDR_W-1:LOW_W], s[LOW_W-1:0]};
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] dCnt;
    logic [CNT_W-1:0] cntSub;
    logic [CNT_W-1:0] cntNext;
    logic             lowBorrow;
    logic             fullBorrow;
    logic             expire;

    always_comb begin
      dCnt       = strobe[c].word ? CNT_W'(2) : CNT_W'(1);
      cntSub     = cntQ[c] - dCnt;
      lowBorrow  = cntQ[c][LOW_W-1:0] < dCnt[LOW_W-1:0];
      fullBorrow = cntQ[c] < dCnt;
      cntNext    = strobe[c].tgtFull ? cntSub
                                     : {cntQ[c][CNT_W-1:LOW_W], cntSub[LOW_W-1:0]};
      expire     = strobe[c].tgtFull ? fullBorrow : lowBorrow;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqQ[c]    <= '0;
        tgtQ[c]    <= '0;
        cntQ[c]    <= '0;
        termCnt[c] <= 1'b0;
      end else begin
        if (strobe[c].loadReq)
          reqQ[c] <= wrData;
        else if (strobe[c].step)
          reqQ[c] <= addrNext(reqQ[c], strobe[c].reqDec, strobe[c].word, strobe[c].reqFull);

        if (strobe[c].loadTgt)
          tgtQ[c] <= wrData;
        else if (strobe[c].step)
          tgtQ[c] <= addrNext(tgtQ[c], strobe[c].tgtDec, strobe[c].word, strobe[c].tgtFull);

        if (strobe[c].loadCnt) begin
          cntQ[c]    <= wrData[CNT_W-1:0];
          termCnt[c] <= 1'b0;
        end else if (strobe[c].step) begin
          cntQ[c]    <= cntNext;
          termCnt[c] <= expire;
        end else begin
          termCnt[c] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 24,
  parameter int LOW_W  = 16,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int OVF_W  = 2 * NCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W+1:0]   wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [CH_W+1:0]   rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic [NCH-1:0]    stepCh,
  input  logic [NCH-1:0]    stepWord,
  input  logic [NCH-1:0]    reqDec,
  input  logic [NCH-1:0]    tgtDec,
  output logic [NCH-1:0]    termCnt
);

  chStrobe_t         strobe [NCH];
  logic [OVF_W-1:0]  ovfQ;
  logic [ADDR_W-1:0] reqQ [NCH];
  logic [ADDR_W-1:0] tgtQ [NCH];
  logic [CNT_W-1:0]  cntQ [NCH];
  logic [CH_W-1:0]   rdCh;

  dma_seq_ctrl #(.NCH(NCH), .CH_W(CH_W), .OVF_W(OVF_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrOvf    (wrData[OVF_W-1:0]),
    .stepCh   (stepCh),
    .stepWord (stepWord),
    .reqDec   (reqDec),
    .tgtDec   (tgtDec),
    .strobe   (strobe),
    .ovfQ     (ovfQ)
  );

  dma_seq_dpath #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_W(LOW_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .reqQ    (reqQ),
    .tgtQ    (tgtQ),
    .cntQ    (cntQ),
    .termCnt (termCnt)
  );

  assign rdCh = rdSel[CH_W+1:2];

  always_comb begin
    unique case (field_t'(rdSel[1:0]))
      F_REQ:   rdData = reqQ[rdCh];
      F_TGT:   rdData = tgtQ[rdCh];
      F_CNT:   rdData = ADDR_W'(cntQ[rdCh]);
      default: rdData = ADDR_W'(ovfQ);
    endcase
  end

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 24,
  parameter int LOW_W  = 16,
  parameter int CH_W   = 1,
  parameter int OVF_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CH_W+1:0]   wrSel,
  input logic [ADDR_W-1:0] wrData,
  input logic [CH_W+1:0]   rdSel,
  input logic [ADDR_W-1:0] rdData,
  input logic [NCH-1:0]    stepCh,
  input logic [NCH-1:0]    termCnt,
  input logic [OVF_W-1:0]  ovfQ,
  input logic [ADDR_W-1:0] reqQ [NCH],
  input logic [ADDR_W-1:0] tgtQ [NCH],
  input logic [CNT_W-1:0]  cntQ [NCH]
);

  // R3: reserved enable bits never read back as one
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel[1:0] == 2'd3) |-> (rdData[ADDR_W-1:OVF_W] == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R9: a terminal-count pulse follows a step on the same channel
    a_r9_tc_after_step: assert property (@(posedge clk) disable iff (!rstN)
      termCnt[c] |-> $past(stepCh[c]));

    // R10: a counter write wins over a concurrent step
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
      $past(wrEn && wrSel == {CH_W'(c), 2'd2}) |->
        (cntQ[c] == $past(wrData[CNT_W-1:0])) && !termCnt[c]);

    // R6, R8: 16-bit target mode keeps the upper target bits
    a_r6_tgt_upper_frozen: assert property (@(posedge clk) disable iff (!rstN)
      $past(stepCh[c] && !ovfQ[2*c] && !(wrEn && wrSel == {CH_W'(c), 2'd1})) |->
        (tgtQ[c][ADDR_W-1:LOW_W] == $past(tgtQ[c][ADDR_W-1:LOW_W])));

    // R8: 16-bit requester mode keeps the upper requester bits
    a_r8_req_upper_frozen: assert property (@(posedge clk) disable iff (!rstN)
      $past(stepCh[c] && !ovfQ[2*c+1] && !(wrEn && wrSel == {CH_W'(c), 2'd0})) |->
        (reqQ[c][ADDR_W-1:LOW_W] == $past(reqQ[c][ADDR_W-1:LOW_W])));

    // R11: no step and no write on this channel leaves its counter alone
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
      $past(!stepCh[c] && !(wrEn && wrSel == {CH_W'(c), 2'd2})) |->
        (cntQ[c] == $past(cntQ[c])));
  end

endmodule

bind dma_addr_seq dma_addr_seq_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_W(LOW_W), .CH_W(CH_W), .OVF_W(OVF_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .rdSel   (rdSel),
  .rdData  (rdData),
  .stepCh  (stepCh),
  .termCnt (termCnt),
  .ovfQ    (ovfQ),
  .reqQ    (reqQ),
  .tgtQ    (tgtQ),
  .cntQ    (cntQ)
);

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrSel;
  logic [25:0] wrData;
  logic [2:0]  rdSel;
  logic [25:0] rdData;
  logic [1:0]  stepCh;
  logic [1:0]  stepWord;
  logic [1:0]  reqDec;
  logic [1:0]  tgtDec;
  logic [1:0]  termCnt;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dma_addr_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .stepCh(stepCh), .stepWord(stepWord),
    .reqDec(reqDec), .tgtDec(tgtDec), .termCnt(termCnt)
  );

  typedef struct packed {
    logic        ch;
    logic [3:0]  ovf;
    logic        word;
    logic        rdec;
    logic        tdec;
    logic [25:0] req;
    logic [25:0] tgt;
    logic [23:0] cnt;
    logic [25:0] eReq;
    logic [25:0] eTgt;
    logic [23:0] eCnt;
    logic        eTc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R4: plain byte increment
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 26'h0000010, 26'h0000020, 24'h000005,
      26'h0000011, 26'h0000021, 24'h000004, 1'b0, 4'd4},
    // R6: 16-bit wrap with frozen upper bits, counter expires
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 26'h012FFFF, 26'h02AFFFF, 24'h050000,
      26'h0120000, 26'h02A0000, 24'h05FFFF, 1'b1, 4'd6},
    // R7: same start in full mode carries and borrows
    '{1'b0, 4'h3, 1'b0, 1'b0, 1'b0, 26'h012FFFF, 26'h02AFFFF, 24'h050000,
      26'h0130000, 26'h02B0000, 24'h04FFFF, 1'b0, 4'd7},
    // R5: word decrement full width, 24-bit expiry
    '{1'b1, 4'hC, 1'b1, 1'b1, 1'b1, 26'h0100000, 26'h0000001, 24'h000001,
      26'h00FFFFE, 26'h3FFFFFF, 24'hFFFFFF, 1'b1, 4'd5},
    // R6: word decrement in 16-bit mode
    '{1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 26'h0100000, 26'h3AB0001, 24'h000001,
      26'h010FFFE, 26'h3ABFFFF, 24'h00FFFF, 1'b1, 4'd6},
    // R8: ch1 requester full, target/count 16-bit
    '{1'b1, 4'h8, 1'b0, 1'b0, 1'b0, 26'h000FFFF, 26'h000FFFF, 24'h010000,
      26'h0010000, 26'h0000000, 24'h01FFFF, 1'b1, 4'd8},
    // R8: ch0 target/count full, requester 16-bit
    '{1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 26'h000FFFF, 26'h000FFFF, 24'h010000,
      26'h0000000, 26'h0010000, 24'h00FFFF, 1'b0, 4'd8},
    // R7: word increment wraps the full target width
    '{1'b0, 4'h3, 1'b1, 1'b0, 1'b0, 26'h0000100, 26'h3FFFFFE, 24'h000003,
      26'h0000102, 26'h0000000, 24'h000001, 1'b0, 4'd7},
    // R9: full-mode counter at zero expires
    '{1'b1, 4'hC, 1'b0, 1'b0, 1'b0, 26'h0000000, 26'h0000000, 24'h000000,
      26'h0000001, 26'h0000001, 24'hFFFFFF, 1'b1, 4'd9},
    // R9: full mode does not expire at a 64K boundary
    '{1'b1, 4'hC, 1'b0, 1'b1, 1'b1, 26'h0010000, 26'h0020000, 24'h010000,
      26'h000FFFF, 26'h001FFFF, 24'h00FFFF, 1'b0, 4'd9}
  };

  task automatic chk(input bit ok, input string rq, input logic [25:0] act, input logic [25:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [25:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] sel, input logic [25:0] exp, input string rq);
    rdSel = sel;
    #1;
    chk(rdData === exp, rq, rdData, exp);
  endtask

  task automatic doStep(input int ch, input logic word, input logic rdec, input logic tdec,
                        output logic tc);
    @(negedge clk);
    stepCh = '0; stepCh[ch] = 1'b1;
    stepWord[ch] = word; reqDec[ch] = rdec; tgtDec[ch] = tdec;
    @(negedge clk);
    stepCh = '0;
    tc = termCnt[ch];
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic tc;
    logic [2:0] s;
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0; rdSel = '0;
    stepCh = '0; stepWord = '0; reqDec = '0; tgtDec = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every register and the pulses
    for (int i = 0; i < 8; i++) begin
      s = 3'(i);
      rdChk(s, 26'h0, "R1");
    end
    chk(termCnt == 2'b00, "R1", 26'(termCnt), 26'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      wr(3'b011, 26'(VEC[v].ovf));
      wr({VEC[v].ch, 2'b00}, VEC[v].req);
      wr({VEC[v].ch, 2'b01}, VEC[v].tgt);
      wr({VEC[v].ch, 2'b10}, 26'(VEC[v].cnt));
      doStep(int'(VEC[v].ch), VEC[v].word, VEC[v].rdec, VEC[v].tdec, tc);
      chk(tc === VEC[v].eTc, $sformatf("R%0d vec%0d tc", VEC[v].rq, v), 26'(tc), 26'(VEC[v].eTc));
      rdChk({VEC[v].ch, 2'b00}, VEC[v].eReq, $sformatf("R%0d vec%0d req", VEC[v].rq, v));
      rdChk({VEC[v].ch, 2'b01}, VEC[v].eTgt, $sformatf("R%0d vec%0d tgt", VEC[v].rq, v));
      rdChk({VEC[v].ch, 2'b10}, 26'(VEC[v].eCnt), $sformatf("R%0d vec%0d cnt", VEC[v].rq, v));
    end

    // R3: reserved enable bits ignore writes, read as zero
    wr(3'b111, 26'h3FFFFFF);
    rdChk(3'b011, 26'h000000F, "R3");
    rdChk(3'b111, 26'h000000F, "R3 alias");

    // R2: counter keeps only 24 bits
    wr(3'b010, 26'h3FFFFFF);
    rdChk(3'b010, 26'h0FFFFFF, "R2");

    // R10: counter write beats a same-cycle step; requester still steps
    wr(3'b011, 26'h0);
    wr(3'b000, 26'h0000040);
    wr(3'b010, 26'h0);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'b010; wrData = 26'h0000123;
    stepCh = 2'b01; stepWord = 2'b00; reqDec = 2'b00; tgtDec = 2'b00;
    @(negedge clk);
    wrEn = 1'b0; stepCh = '0;
    chk(termCnt[0] === 1'b0, "R10 tc", 26'(termCnt[0]), 26'h0);
    rdChk(3'b010, 26'h0000123, "R10 cnt");
    rdChk(3'b000, 26'h0000041, "R10 req");

    // R5: three words programmed as 5, expiry on the third step
    wr(3'b110, 26'h0000005);
    doStep(1, 1'b1, 1'b0, 1'b0, tc);
    chk(tc === 1'b0, "R5 step1", 26'(tc), 26'h0);
    doStep(1, 1'b1, 1'b0, 1'b0, tc);
    chk(tc === 1'b0, "R5 step2", 26'(tc), 26'h0);
    doStep(1, 1'b1, 1'b0, 1'b0, tc);
    chk(tc === 1'b1, "R5 step3", 26'(tc), 26'h1);
    rdChk(3'b110, 26'h000FFFF, "R5 cnt");
    @(negedge clk);
    chk(termCnt === 2'b00, "R9 one-cycle pulse", 26'(termCnt), 26'h0);

    // R11: channel 0 untouched by channel 1 activity
    rdChk(3'b010, 26'h0000123, "R11 cnt");
    rdChk(3'b000, 26'h0000041, "R11 req");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule